// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that owns one 8-bit port latch and turns it into per-pin drive controls for a quasi-bidirectional port. There is no direction register. A latch bit of 0 pulls its pin low. A latch bit of 1 leaves only a weak pull-up, so the pin can be read as an input. When a bit goes from 0 to 1, a short strong pull-up is switched on to speed up the rising edge. It ends at the next falling edge of SCL.

The block oversamples SCL and SDA with the system clock and detects START and STOP conditions itself. It drives SDA only through an open-drain enable. The bus master writes any number of bytes to the latch in one transfer, or reads any number of pin snapshots in one transfer. Three strap inputs complete the 7-bit target address, so eight of these blocks can share one bus.

Top module: `qbx_port_expander`

## Requirements
- R1: After reset the latch holds all ones: `pinWeakUp` = 0xFF, `pinPullDown` = 0x00, `pinStrongUp` = 0x00, and `sdaOe` = 0.
- R2: The block answers only the address byte whose upper seven bits are 0100 followed by `strapAddr[2:0]`, with bit 0 as the direction (1 = read, 0 = write). It acknowledges by holding SDA low during the ninth clock. On any other address it does not acknowledge, and it ignores the rest of the transfer.
- R3: In a write transfer every data byte is acknowledged. Each byte is copied into the latch at the SCL falling edge that ends its acknowledge clock. In a multi-byte write, the latch holds the last complete byte.
- R4: For every pin, `pinPullDown` is the inverse of the latch bit and `pinWeakUp` equals the latch bit.
- R5: At a latch update, `pinStrongUp` is set for exactly the bits that change from 0 to 1. All of them clear at the next SCL falling edge.
- R6: In a read transfer the block sends `pinIn` MSB first. The pins are sampled when each byte begins, and a new sample is taken for every byte that follows a master acknowledge.
- R7: After a master not-acknowledge the block releases SDA and stays silent until the next START.
- R8: A START or STOP in the middle of a byte ends the transfer and leaves the latch unchanged.
- R9: A repeated START begins a new address phase, and the transfer that follows it works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock level |
| sda | input | 1 | Bus data level (wired-AND line) |
| sdaOe | output | 1 | When 1, the open-drain driver pulls SDA low |
| strapAddr | input | 3 | Low three bits of the target address |
| pinIn | input | 8 | Sampled pin levels |
| pinPullDown | output | 8 | Per-pin enable for the low driver |
| pinWeakUp | output | 8 | Per-pin enable for the weak current-source pull-up |
| pinStrongUp | output | 8 | Per-pin enable for the short strong pull-up |

## Verification
The hardest case to reach from the ports is the strong pull-up window. It opens only when a latch bit goes from 0 to 1, and it must close on the very next SCL fall, not at a STOP. The stimulus writes two bytes back to back whose bit patterns differ in both directions and samples `pinStrongUp` after the second acknowledge. It then clocks exactly one further data bit and aborts the byte with a STOP. This shows in one sequence that the pulse closes on that first fall and that the half-sent byte never reaches the latch. Read resampling is exercised by changing `pinIn` during each acknowledge clock, so every byte must carry a different value.

// File: rtl/qbx_pkg.sv
package qbx_pkg;

  // Strobes from the bus control to the datapath, valid for one clk cycle.
  typedef struct packed {
    logic shiftIn;   // capture rxBit into the shift register
    logic rxBit;     // synchronised SDA level
    logic loadPins;  // snapshot pinIn into the shift register
    logic shiftOut;  // advance the transmit bit
    logic commit;    // copy the shift register into the port latch
    logic sclFall;   // SCL falling edge seen this cycle
  } qbxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } qbxState_t;

endpackage

// File: rtl/qbx_ctrl.sv
module qbx_ctrl
  import qbx_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int STRAP_W = 3,
  parameter int FIXED_W = 4,
  parameter logic [FIXED_W-1:0] FIXED_ADDR = 4'b0100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [PORT_W-1:0] rxByte,
  input  logic txBit,
  output qbxStrobe_t strobe,
  output logic sdaOe
);

  localparam int CNT_W = $clog2(PORT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PORT_W - 1);

  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;
  qbxState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic gotByte, isRead, ackDrive, masterAck;
  logic addrMatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclS <= 1'b1;
      sdaS <= 1'b1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclS <= scl;
      sdaS <= sda;
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;
  assign addrMatch = (rxByte[PORT_W-1:1] == {FIXED_ADDR, strapAddr});

  always_comb begin
    strobe = '0;
    strobe.rxBit = sdaS;
    strobe.sclFall = sclFall;
    if (!startCond && !stopCond) begin
      case (state)
        ST_ADDR, ST_WR_DATA: strobe.shiftIn = sclRise;
        ST_ADDR_ACK: strobe.loadPins = sclFall & isRead;
        ST_WR_ACK: strobe.commit = sclFall;
        ST_RD_DATA: strobe.shiftOut = sclFall && (bitCnt != LAST_BIT);
        ST_RD_ACK: strobe.loadPins = sclFall & masterAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      gotByte <= 1'b0;
      isRead <= 1'b0;
      ackDrive <= 1'b0;
      masterAck <= 1'b0;
    end else if (startCond) begin
      state <= ST_ADDR;
      bitCnt <= '0;
      gotByte <= 1'b0;
      ackDrive <= 1'b0;
    end else if (stopCond) begin
      state <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR_DATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) gotByte <= 1'b1;
          end else if (sclFall && gotByte) begin
            gotByte <= 1'b0;
            if (state == ST_WR_DATA) begin
              ackDrive <= 1'b1;
              state <= ST_WR_ACK;
            end else if (addrMatch) begin
              isRead <= rxByte[0];
              ackDrive <= 1'b1;
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt <= '0;
            state <= isRead ? ST_RD_DATA : ST_WR_DATA;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            state <= ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              state <= ST_RD_ACK;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) masterAck <= ~sdaS;
          else if (sclFall) state <= masterAck ? ST_RD_DATA : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaOe = ackDrive | ((state == ST_RD_DATA) & ~txBit);

  // SDA may only move while SCL is low, never inside a data-valid window.
  assert_sda_changes_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaOe) |-> !sclS);

  // A START always reopens the address phase, mid-byte or repeated.
  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    startCond |=> (state == ST_ADDR));

  // A STOP ends the transfer and frees the line.
  assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stopCond |=> (state == ST_IDLE) && !ackDrive);

  // After a master not-acknowledge nothing is driven.
  assert_nack_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK) && sclFall && !masterAck && !startCond && !stopCond
      |=> !sdaOe);

endmodule

// File: rtl/qbx_datapath.sv
module qbx_datapath
  import qbx_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  qbxStrobe_t strobe,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] rxByte,
  output logic txBit,
  output logic [PORT_W-1:0] pinPullDown,
  output logic [PORT_W-1:0] pinWeakUp,
  output logic [PORT_W-1:0] pinStrongUp
);

  logic [PORT_W-1:0] shiftReg;
  logic [PORT_W-1:0] portLatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobe.loadPins) begin
      shiftReg <= pinIn;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[PORT_W-2:0], strobe.rxBit};
    end else if (strobe.shiftOut) begin
      shiftReg <= {shiftReg[PORT_W-2:0], 1'b1};
    end
  end

  assign rxByte = shiftReg;
  assign txBit = shiftReg[PORT_W-1];

  for (genvar p = 0; p < PORT_W; p++) begin : gPin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        portLatch[p] <= 1'b1;
        pinStrongUp[p] <= 1'b0;
      end else if (strobe.commit) begin
        portLatch[p] <= shiftReg[p];
        pinStrongUp[p] <= shiftReg[p] & ~portLatch[p];
      end else if (strobe.sclFall) begin
        pinStrongUp[p] <= 1'b0;
      end
    end
    assign pinPullDown[p] = ~portLatch[p];
    assign pinWeakUp[p] = portLatch[p];
  end

  // The latch moves only on a commit strobe from the control.
  assert_latch_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (portLatch != $past(portLatch)) |-> $past(strobe.commit));

  // Each newly raised strong pull-up belongs to a bit that was low before.
  assert_strong_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinStrongUp & ~$past(pinStrongUp)) != '0)
      |-> (((pinStrongUp & ~$past(pinStrongUp)) & $past(portLatch)) == '0));

  // The strong pull-up window closes at the next SCL fall.
  assert_strong_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sclFall && !strobe.commit |=> (pinStrongUp == '0));

  // Pin snapshots and latch commits never share a cycle.
  assert_load_commit_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.loadPins && strobe.commit));

endmodule

// File: rtl/qbx_port_expander.sv
module qbx_port_expander
  import qbx_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int STRAP_W = 3,
  parameter int FIXED_W = 4,
  parameter logic [FIXED_W-1:0] FIXED_ADDR = 4'b0100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic sdaOe,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinPullDown,
  output logic [PORT_W-1:0] pinWeakUp,
  output logic [PORT_W-1:0] pinStrongUp
);

  qbxStrobe_t strobe;
  logic [PORT_W-1:0] rxByte;
  logic txBit;

  qbx_ctrl #(
    .PORT_W(PORT_W), .STRAP_W(STRAP_W), .FIXED_W(FIXED_W), .FIXED_ADDR(FIXED_ADDR)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .strapAddr(strapAddr),
    .rxByte(rxByte), .txBit(txBit), .strobe(strobe), .sdaOe(sdaOe)
  );

  qbx_datapath #(.PORT_W(PORT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pinIn(pinIn),
    .rxByte(rxByte), .txBit(txBit), .pinPullDown(pinPullDown),
    .pinWeakUp(pinWeakUp), .pinStrongUp(pinStrongUp)
  );

endmodule

// File: tb/qbx_port_expander_tb_top.sv
module qbx_port_expander_tb_top;

  localparam int Q = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic [2:0] strapAddr = 3'b101;
  logic [7:0] pinIn = 8'h00;
  logic [7:0] pinPullDown, pinWeakUp, pinStrongUp;
  wire sdaLine = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  qbx_port_expander dut_i (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sdaLine), .sdaOe(sdaOe),
    .strapAddr(strapAddr), .pinIn(pinIn), .pinPullDown(pinPullDown),
    .pinWeakUp(pinWeakUp), .pinStrongUp(pinStrongUp)
  );

  // Scoreboard.
  string reqQ[$];
  logic [7:0] expQ[$];
  logic [7:0] obsVal;
  event obsEv;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL scoreboard: observation with no expected item, got %h", obsVal);
      end else begin
        string r;
        logic [7:0] e;
        r = reqQ.pop_front();
        e = expQ.pop_front();
        checks++;
        if (obsVal !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", r, obsVal, e);
        end
      end
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    reqQ.push_back(req);
    expQ.push_back(exp);
    obsVal = got;
    -> obsEv;
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; #Q;
    scl = 1'b1; #Q;
    sdaM = 1'b0; #Q;
    scl = 1'b0; #Q;
  endtask

  task automatic busStop();
    sdaM = 1'b0; #Q;
    scl = 1'b1; #Q;
    sdaM = 1'b1; #Q;
  endtask

  task automatic writeBit(input logic b);
    sdaM = b; #Q;
    scl = 1'b1; #(2*Q);
    scl = 1'b0; #Q;
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; #Q;
    scl = 1'b1; #Q;
    b = sdaLine; #Q;
    scl = 1'b0; #Q;
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic readByte(input logic mAck, input logic [7:0] nextPins, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    pinIn = nextPins;
    writeBit(~mAck);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    #100 rst_n = 1'b1;
    #100;

    // R1 reset state
    check("R1 weakUp", pinWeakUp, 8'hFF);
    check("R1 pullDown", pinPullDown, 8'h00);
    check("R1 strongUp", pinStrongUp, 8'h00);
    check("R1 sdaOe", {7'b0, sdaOe}, 8'h00);

    // R2/R3/R4/R5 two-byte write at strap 101
    busStart();
    writeByte(8'h4A, ack);
    check("R2 address ack", {7'b0, ack}, 8'h01);
    writeByte(8'h3C, ack);
    check("R3 data ack", {7'b0, ack}, 8'h01);
    check("R3 latch first byte", pinWeakUp, 8'h3C);
    check("R4 pullDown inverse", pinPullDown, 8'hC3);
    check("R5 no rise no strong", pinStrongUp, 8'h00);
    writeByte(8'hA5, ack);
    check("R3 last byte wins", pinWeakUp, 8'hA5);
    check("R5 strong on 0-to-1 bits", pinStrongUp, 8'h81);
    writeBit(1'b1);
    check("R5 strong cleared at next fall", pinStrongUp, 8'h00);
    busStop();
    check("R8 stop mid-byte keeps latch", pinWeakUp, 8'hA5);

    // R2 foreign address is ignored
    busStart();
    writeByte(8'h44, ack);
    check("R2 foreign address nack", {7'b0, ack}, 8'h00);
    writeByte(8'h00, ack);
    check("R2 foreign data nack", {7'b0, ack}, 8'h00);
    check("R2 foreign write no effect", pinWeakUp, 8'hA5);
    busStop();

    // R6/R7 multi-byte read with resampling
    pinIn = 8'h5E;
    busStart();
    writeByte(8'h4B, ack);
    check("R6 read address ack", {7'b0, ack}, 8'h01);
    readByte(1'b1, 8'h91, rd);
    check("R6 first read byte", rd, 8'h5E);
    readByte(1'b0, 8'h00, rd);
    check("R6 resampled second byte", rd, 8'h91);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      readBit(b);
      rd[i] = b;
    end
    check("R7 released after nack", rd, 8'hFF);
    busStop();

    // R8/R9 START mid-byte then repeated-start write
    busStart();
    writeByte(8'h4A, ack);
    for (int i = 0; i < 4; i++) writeBit(1'b0);
    busStart();
    check("R8 start mid-byte keeps latch", pinWeakUp, 8'hA5);
    writeByte(8'h4A, ack);
    check("R9 repeated start address ack", {7'b0, ack}, 8'h01);
    writeByte(8'h66, ack);
    check("R9 write after repeated start", pinWeakUp, 8'h66);
    check("R5 strong after repeated start", pinStrongUp, 8'h42);
    busStop();

    // R2 new strap value, R4 all pins low
    strapAddr = 3'b010;
    #100;
    busStart();
    writeByte(8'h44, ack);
    check("R2 new strap ack", {7'b0, ack}, 8'h01);
    writeByte(8'h00, ack);
    check("R4 all pulled down", pinPullDown, 8'hFF);
    check("R4 no weak pull-up", pinWeakUp, 8'h00);
    busStop();

    #100;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule